// File: doc/BRIEF.md
# Out-of-Frame SPI Register Master

This block is an SPI master for a sensor that talks in fixed 32-bit frames and answers each request one frame late. A client presents read or write requests (8-bit register address, 16-bit write data, capture flag) on a valid/ready handshake. The block builds the request frame, appends a 3-bit CRC, and shifts the frame out MSB first in SPI mode 0 (clock idles low, data launched on the falling edge, sampled on the rising edge).

A write costs one frame and produces no response. A read sends the request frame, waits the required chip-select gap, then sends an all-zero filler frame. The answer to the request arrives during that filler frame. The received word is checked bit-serially with the same CRC-3, and its status bits are checked as well. The block then returns the 16-bit payload with a one-cycle valid pulse and an error flag.

Chip select is held inactive for a parameterised number of clock cycles between frames, including before the first frame after reset. This meets the sensor's minimum deselect time.

Top module: `oof_spi_master`

## Requirements
- R1: A request frame carries, from MSB: bits 31:30 = 0, bits 29:22 = address, bit 21 = 1 for write / 0 for read, bit 20 = capture flag on reads (0 on writes), bit 19 = 0, bits 18:3 = write data on writes (0 on reads), bits 2:0 = CRC.
- R2: The CRC is a 3-bit register seeded with 3'b101. It is updated once per frame bit, MSB first, over all 32 bits with the CRC field taken as zero: next = {crc[1:0], bit} XOR (crc[2] ? 3'b011 : 3'b000).
- R3: Frames are sent MSB first in SPI mode 0. sclk_o is low whenever cs_n_o is high. mosi_o is stable while sclk_o is high. miso_i is sampled on the rising edge. Each frame has exactly 32 rising sclk_o edges.
- R4: A read takes two frames: the request, then an all-zero filler frame. Bits 19:4 of the word received during the filler frame appear on rsp_data_o with a single-cycle rsp_valid_o pulse.
- R5: A write takes one frame and raises no rsp_valid_o.
- R6: rsp_err_o is set with rsp_valid_o when the CRC of R2 run over all 32 received bits is not zero.
- R7: rsp_err_o is set when received bits 31 and 3 are both 1. Either bit alone, with a good CRC, gives rsp_err_o = 0.
- R8: cs_n_o stays high for at least GAP_CYCLES clock cycles between frames, and after reset before the first frame.
- R9: req_ready_o is high only when no transaction is in progress and no gap is pending. A request is taken when req_valid_i and req_ready_o are both high.
- R10: During and after reset, cs_n_o = 1, sclk_o = 0 and rsp_valid_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Register address |
| req_wdata_i | input | 16 | Write data |
| req_capture_i | input | 1 | Capture flag for reads |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_err_o | output | 1 | Response failed CRC or status check |
| rsp_data_o | output | 16 | Read data |
| sclk_o | output | 1 | SPI clock, idle low |
| mosi_o | output | 1 | Serial data to sensor |
| miso_i | input | 1 | Serial data from sensor |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
A corrupted shift or bit counter shows at once at the pins: a frame with other than 32 clock pulses, or a request word that differs from the expected one when chip select rises. A wrong sequencer state shows within one transaction. Examples are a missing filler frame, a response on a write, or a valid pulse that never comes. A seed, polynomial or status-decode fault shows on the next response as a wrong rsp_err_o. A gap counter fault shows as a short deselect time, measured between every pair of frames.

// File: rtl/oof_spi_pkg.sv
package oof_spi_pkg;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int CRC_W   = 3;
  localparam logic [CRC_W-1:0] CRC_SEED = 3'b101;
  localparam logic [CRC_W-1:0] CRC_POLY = 3'b011;

  typedef enum logic [1:0] {PHY_GAP, PHY_IDLE, PHY_SHIFT, PHY_TAIL} phy_st_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_WR, SQ_RD_REQ, SQ_RD_FILL, SQ_RD_RSP} seq_st_e;

  typedef struct packed {
    logic [1:0]        bus;
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic              cap;
    logic              rsvd;
    logic [DATA_W-1:0] data;
    logic [CRC_W-1:0]  crc;
  } req_frame_t;

  function automatic logic [CRC_W-1:0] crc3_step(logic [CRC_W-1:0] c, logic b);
    return {c[CRC_W-2:0], b} ^ (c[CRC_W-1] ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc3_frame(logic [FRAME_W-1:0] f);
    logic [CRC_W-1:0] c;
    c = CRC_SEED;
    for (int i = FRAME_W - 1; i >= 0; i--) c = crc3_step(c, f[i]);
    return c;
  endfunction
endpackage

// File: rtl/oof_crc3_serial.sv
module oof_crc3_serial
  import oof_spi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_SEED;
    else if (init_i) crc_o <= CRC_SEED;
    else if (en_i)   crc_o <= crc3_step(crc_o, bit_i);
  end
endmodule

// File: rtl/oof_frame_phy.sv
module oof_frame_phy
  import oof_spi_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int GAP_CYCLES = 160
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] tx_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] rx_o,
  output logic [CRC_W-1:0]   rx_crc_o,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_n_o
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam int BIT_W = $clog2(FRAME_W);

  phy_st_e            st;
  logic [DIV_W-1:0]   div;
  logic [GAP_W-1:0]   gap;
  logic [BIT_W-1:0]   bitc;
  logic [FRAME_W-1:0] sh;
  logic               tick, sample, launch;

  assign tick    = (div == DIV_W'(CLK_DIV - 1));
  assign sample  = (st == PHY_SHIFT) && tick && !sclk_o;
  assign launch  = (st == PHY_IDLE) && start_i;
  assign ready_o = (st == PHY_IDLE);
  assign mosi_o  = sh[FRAME_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= PHY_GAP;
      cs_n_o <= 1'b1;
      sclk_o <= 1'b0;
      div    <= '0;
      gap    <= '0;
      bitc   <= '0;
      sh     <= '0;
      rx_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        PHY_GAP: begin
          if (gap == GAP_W'(GAP_CYCLES - 1)) st <= PHY_IDLE;
          else gap <= gap + 1'b1;
        end
        PHY_IDLE: begin
          if (start_i) begin
            sh     <= tx_i;
            cs_n_o <= 1'b0;
            div    <= '0;
            bitc   <= '0;
            st     <= PHY_SHIFT;
          end
        end
        PHY_SHIFT: begin
          if (tick) begin
            div <= '0;
            if (!sclk_o) begin
              sclk_o <= 1'b1;
              rx_o   <= {rx_o[FRAME_W-2:0], miso_i};
            end else begin
              sclk_o <= 1'b0;
              if (bitc == BIT_W'(FRAME_W - 1)) begin
                st <= PHY_TAIL;
              end else begin
                sh   <= {sh[FRAME_W-2:0], 1'b0};
                bitc <= bitc + 1'b1;
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        PHY_TAIL: begin
          if (tick) begin
            div    <= '0;
            cs_n_o <= 1'b1;
            done_o <= 1'b1;
            gap    <= '0;
            st     <= PHY_GAP;
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= PHY_GAP;
      endcase
    end
  end

  oof_crc3_serial u_rx_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (launch),
    .en_i   (sample),
    .bit_i  (miso_i),
    .crc_o  (rx_crc_o)
  );
endmodule

// File: rtl/oof_seq.sv
module oof_seq
  import oof_spi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic               req_capture_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [DATA_W-1:0]  rsp_data_o,
  input  logic               phy_ready_i,
  input  logic               phy_done_i,
  input  logic [FRAME_W-1:0] phy_rx_i,
  input  logic [CRC_W-1:0]   phy_crc_i,
  output logic               phy_start_o,
  output logic [FRAME_W-1:0] phy_tx_o
);
  seq_st_e    st;
  req_frame_t body;
  logic       accept;
  logic       unused_rx;

  assign unused_rx = ^{phy_rx_i[FRAME_W-2:DATA_W+4], phy_rx_i[2:0]};

  always_comb begin
    body      = '0;
    body.addr = req_addr_i;
    body.wr   = req_write_i;
    body.cap  = req_write_i ? 1'b0 : req_capture_i;
    body.data = req_write_i ? req_wdata_i : '0;
  end

  assign req_ready_o = (st == SQ_IDLE) && phy_ready_i;
  assign accept      = req_valid_i && req_ready_o;
  assign phy_start_o = accept || ((st == SQ_RD_FILL) && phy_ready_i);
  // filler frame is all zeros
  assign phy_tx_o    = (st == SQ_IDLE) ? {body[FRAME_W-1:CRC_W], crc3_frame(body)} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st          <= SQ_IDLE;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (st)
        SQ_IDLE:    if (accept) st <= req_write_i ? SQ_WR : SQ_RD_REQ;
        SQ_WR:      if (phy_done_i) st <= SQ_IDLE;
        SQ_RD_REQ:  if (phy_done_i) st <= SQ_RD_FILL;
        SQ_RD_FILL: if (phy_ready_i) st <= SQ_RD_RSP;
        SQ_RD_RSP: begin
          if (phy_done_i) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= phy_rx_i[DATA_W+3:4];
            rsp_err_o   <= (phy_crc_i != '0) || (phy_rx_i[FRAME_W-1] && phy_rx_i[3]);
            st          <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/oof_spi_master.sv
module oof_spi_master
  import oof_spi_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int GAP_CYCLES = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_capture_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o
);
  logic               phy_ready, phy_done, phy_start;
  logic [FRAME_W-1:0] phy_rx, phy_tx;
  logic [CRC_W-1:0]   phy_crc;

  oof_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_write_i   (req_write_i),
    .req_addr_i    (req_addr_i),
    .req_wdata_i   (req_wdata_i),
    .req_capture_i (req_capture_i),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_err_o     (rsp_err_o),
    .rsp_data_o    (rsp_data_o),
    .phy_ready_i   (phy_ready),
    .phy_done_i    (phy_done),
    .phy_rx_i      (phy_rx),
    .phy_crc_i     (phy_crc),
    .phy_start_o   (phy_start),
    .phy_tx_o      (phy_tx)
  );

  oof_frame_phy #(
    .CLK_DIV    (CLK_DIV),
    .GAP_CYCLES (GAP_CYCLES)
  ) u_phy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (phy_start),
    .tx_i     (phy_tx),
    .ready_o  (phy_ready),
    .done_o   (phy_done),
    .rx_o     (phy_rx),
    .rx_crc_o (phy_crc),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .miso_i   (miso_i),
    .cs_n_o   (cs_n_o)
  );
endmodule

// File: rtl/oof_spi_master_chk.sv
module oof_spi_master_chk #(
  parameter int GAP_CYCLES = 160
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic rsp_valid_o,
  input logic req_ready_o
);
  localparam int GW = $clog2(GAP_CYCLES + 2);
  logic [GW-1:0] gap_cnt;
  logic [6:0]    rise_cnt;
  logic          sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_cnt  <= '0;
      rise_cnt <= '0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      if (!cs_n_o) gap_cnt <= '0;
      else if (int'(gap_cnt) < GAP_CYCLES) gap_cnt <= gap_cnt + 1'b1;
      if (cs_n_o) rise_cnt <= '0;
      else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_SCLK_LOW_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o); // R3
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && sclk_o) |-> $stable(mosi_o)); // R3
  AST_FRAME_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (rise_cnt == 7'd32)); // R3
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> (int'(gap_cnt) >= GAP_CYCLES)); // R8
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R4
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> cs_n_o); // R9
endmodule

bind oof_spi_master oof_spi_master_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .mosi_o      (mosi_o),
  .rsp_valid_o (rsp_valid_o),
  .req_ready_o (req_ready_o)
);

// File: tb/oof_spi_master_test.sv
module oof_spi_master_test;
  localparam int DIV = 2;
  localparam int GAP = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_cap = 1'b0;
  logic [7:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, sclk, mosi, cs_n;
  logic [15:0] rsp_data;
  logic miso = 1'b0;

  int errors = 0, checks = 0, rsp_cnt = 0, hi_cnt = 0, fidx = 0, bitn = 0, cur_errk = 0;
  logic [31:0] rxsh = '0, txsh = '0, rsp_next = '0;
  logic [31:0] flog [0:1023];
  logic [15:0] sl_mem [0:255];
  logic [15:0] exp_mem [0:255];

  always #2.5 clk = ~clk;

  oof_spi_master #(.CLK_DIV(DIV), .GAP_CYCLES(GAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_capture_i(req_cap), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_data_o(rsp_data), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] crc3(input logic [31:0] f);
    logic [2:0] c = 3'b101;
    for (int i = 31; i >= 0; i--) begin
      logic x = c[2];
      c = {c[1:0], f[i]};
      if (x) c = c ^ 3'b011;
    end
    return c;
  endfunction

  function automatic logic [31:0] mk_req(input bit wr, input logic [7:0] a, input logic [15:0] d, input bit cap);
    logic [31:0] f = '0;
    f[29:22] = a;
    f[21] = wr;
    f[20] = wr ? 1'b0 : cap;
    f[18:3] = wr ? d : 16'h0;
    f[2:0] = crc3(f);
    return f;
  endfunction

  function automatic logic [31:0] mk_rsp(input bit sd, input logic [10:0] mid, input logic [15:0] d, input bit st, input bit bad);
    logic [31:0] f = {sd, mid, d, st, 3'b000};
    for (int c = 0; c < 8; c++) begin
      if (crc3({f[31:3], 3'(c)}) == 3'b000) begin
        f[2:0] = 3'(c);
        break;
      end
    end
    if (bad) f[0] = ~f[0];
    return f;
  endfunction

  // sensor model: answers each frame in the next one
  always @(negedge cs_n) begin txsh = rsp_next; miso = txsh[31]; bitn = 0; end
  always @(posedge sclk) if (!cs_n) begin rxsh = {rxsh[30:0], mosi}; bitn++; end
  always @(negedge sclk) if (!cs_n) begin txsh = {txsh[30:0], 1'b0}; miso = txsh[31]; end
  always @(posedge cs_n) if (rst_n) begin
    check(bitn == 32, "R3 bits per frame", 32'(bitn), 32);
    flog[fidx] = rxsh;
    fidx++;
    if (rxsh[21]) sl_mem[rxsh[29:22]] = rxsh[18:3];
    if (rxsh != 32'h0 && !rxsh[21]) begin
      case (cur_errk)
        1: rsp_next = mk_rsp(1'b0, 11'($urandom), sl_mem[rxsh[29:22]], 1'b0, 1'b1);
        2: rsp_next = mk_rsp(1'b1, 11'($urandom), sl_mem[rxsh[29:22]], 1'b1, 1'b0);
        3: rsp_next = mk_rsp(1'b1, 11'($urandom), sl_mem[rxsh[29:22]], 1'b0, 1'b0);
        4: rsp_next = mk_rsp(1'b0, 11'($urandom), sl_mem[rxsh[29:22]], 1'b1, 1'b0);
        default: rsp_next = mk_rsp(1'b0, 11'($urandom), sl_mem[rxsh[29:22]], 1'b0, 1'b0);
      endcase
    end else begin
      rsp_next = mk_rsp(1'b1, 11'($urandom), 16'($urandom), 1'b1, 1'b1);
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) rsp_cnt++;
    if (cs_n) hi_cnt++;
    else begin
      if (hi_cnt != 0) check(hi_cnt >= GAP, "R8 cs gap", 32'(hi_cnt), 32'(GAP));
      hi_cnt = 0;
    end
  end

  task automatic issue(input bit wr, input logic [7:0] a, input logic [15:0] d, input bit cap);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_cap = cap;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check(!req_ready, "R9 ready low when busy", 32'(req_ready), 0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    int f0 = fidx, r0 = rsp_cnt;
    issue(1'b1, a, d, 1'b0);
    exp_mem[a] = d;
    while (!req_ready) @(negedge clk);
    check(fidx == f0 + 1, "R5 one frame per write", 32'(fidx - f0), 1);
    check(rsp_cnt == r0, "R5 no response on write", 32'(rsp_cnt - r0), 0);
    check(flog[f0] == mk_req(1'b1, a, d, 1'b0), "R1 R2 write frame", flog[f0], mk_req(1'b1, a, d, 1'b0));
  endtask

  task automatic do_read(input logic [7:0] a, input bit cap, input int errk);
    int f0 = fidx, n = 0;
    bit exp_err = (errk == 1) || (errk == 2);
    cur_errk = errk;
    issue(1'b0, a, 16'h0, cap);
    while (!rsp_valid && n < 5000) begin @(negedge clk); n++; end
    check(rsp_valid, "R4 response pulse", 32'(rsp_valid), 1);
    check(fidx == f0 + 2, "R4 two frames per read", 32'(fidx - f0), 2);
    check(flog[f0] == mk_req(1'b0, a, 16'h0, cap), "R1 R2 read frame", flog[f0], mk_req(1'b0, a, 16'h0, cap));
    check(flog[f0 + 1] == 32'h0, "R4 filler frame zero", flog[f0 + 1], 0);
    check(rsp_data == exp_mem[a], "R4 read data", 32'(rsp_data), 32'(exp_mem[a]));
    if (errk == 1) check(rsp_err == exp_err, "R6 crc error flag", 32'(rsp_err), 32'(exp_err));
    else check(rsp_err == exp_err, "R7 status error flag", 32'(rsp_err), 32'(exp_err));
    @(negedge clk);
    check(!rsp_valid, "R4 single-cycle pulse", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      sl_mem[i] = 16'(i * 16'h9e37) ^ 16'h5a5a;
      exp_mem[i] = 16'(i * 16'h9e37) ^ 16'h5a5a;
    end
    rsp_next = mk_rsp(1'b0, 11'h0, 16'h0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R10 cs high in reset", 32'(cs_n), 1);
    check(sclk == 1'b0, "R10 sclk low in reset", 32'(sclk), 0);
    check(rsp_valid == 1'b0, "R10 no response in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_ready, "R8 R9 initial gap holds ready low", 32'(req_ready), 0);
    check(cs_n && !sclk, "R10 idle after reset", {30'h0, cs_n, sclk}, 32'h2);
    do_write(8'h3c, 16'hbeef);
    do_read(8'h3c, 1'b0, 0);
    do_read(8'hff, 1'b1, 0);
    do_read(8'h00, 1'b0, 1);
    do_read(8'h11, 1'b1, 2);
    do_read(8'h22, 1'b0, 3);
    do_read(8'h33, 1'b0, 4);
    do_write(8'h00, 16'hffff);
    do_read(8'h00, 1'b1, 0);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a = 8'($urandom);
      if ($urandom % 2 == 0) do_write(a, 16'($urandom));
      else do_read(a, 1'($urandom), int'($urandom % 5));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule